// File: doc/BRIEF.md
# Input Delay Window Calibration Sequencer

This block finds a safe sampling point for a source-synchronous ADC data bus by sweeping an input-delay tap through its whole range. At every tap it loads the setting with a one-cycle strobe, lets the delay line settle, and then measures the I lane and the Q lane one after the other with an external ramp-pattern checker. The checker is re-armed by holding its enable low for one cycle and then high for a fixed dwell. The lock and error flags are read on the last cycle of that dwell.

Passing taps form a window. The first passing tap sets the window start, and every later passing tap moves the window stop. When a failing tap arrives while the window is already at least the minimum span wide, the sweep stops early. At the end, the block either programs the midpoint tap or reports why it could not. The results stay on the outputs until the next accepted start.

Top module: `dly_win_cal`

## Requirements
- R1: While reset is asserted, `dly_val_o` is 16, and `dly_load_o`, `chk_en_o`, `lane_q_o`, `busy_o`, `done_o`, `tap_o`, `width_o` and `fail_o` are all 0.
- R2: `dly_val_o` changes only in a cycle in which `dly_load_o` is high, and `dly_load_o` is never high for two cycles in a row. An accepted start loads taps 0, 1, 2 and so on in ascending order, each tap exactly once.
- R3: For each lane of a tap, `chk_en_o` is low for exactly one cycle and then high for exactly DWELL_CYC cycles. It is low whenever the sequencer is not busy.
- R4: Each tap measures the I lane first (`lane_q_o`=0, which means the I lane carries the ramp and the Q lane is held at all ones) and the Q lane second (`lane_q_o`=1). `lane_q_o` does not change while `chk_en_o` stays high.
- R5: A tap passes only if the I-lane flags on the last dwell cycle of the I measurement show lock=1 and error=0, and the Q-lane flags on the last dwell cycle of the Q measurement also show lock=1 and error=0. A missing lock makes the tap fail.
- R6: The first passing tap opens the window, and each later passing tap becomes the window stop, even after failing taps in between. The span is stop minus start. A failing tap that arrives while the span is at least 4 ends the sweep. Otherwise the sweep ends after tap 31. `width_o` reports the final span, and a successful result always has a span of 4 or more.
- R7: `fail_o` is 2'b01 when no tap passed (`width_o`=0) and 2'b10 when the final span is below 4 (`width_o` = span). In both cases `tap_o` is 0, no final load is issued, and `dly_val_o` keeps the last swept tap. The code 2'b11 never occurs.
- R8: On success, `fail_o`=2'b00 and `tap_o` = (start+stop)/2 rounded down. That tap is loaded through `dly_val_o` with a one-cycle `dly_load_o` in the cycle just before `done_o`.
- R9: `done_o` is a one-cycle pulse at the end of each run. `tap_o`, `width_o` and `fail_o` hold their values until the next accepted start, which clears them to 0.
- R10: `start_i` is ignored while `busy_o` is high. `busy_o` is high from the first tap load up to the cycle before `done_o`.
- R11: After each tap load, SETTLE_CYC cycles with both `dly_load_o` and `chk_en_o` low pass before the I lane is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a calibration |
| dly_val_o | output | TAP_W | Tap value presented to the delay line |
| dly_load_o | output | 1 | One-cycle strobe that loads `dly_val_o` |
| chk_en_o | output | 1 | Pattern checker enable; a rising edge re-arms the checker |
| lane_q_o | output | 1 | Lane under test: 0 = I ramp with Q all ones, 1 = Q ramp with I all ones |
| ilock_i | input | 1 | Checker lock flag for the I lane |
| ierr_i | input | 1 | Checker error flag for the I lane |
| qlock_i | input | 1 | Checker lock flag for the Q lane |
| qerr_i | input | 1 | Checker error flag for the Q lane |
| busy_o | output | 1 | Sweep or final load in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tap_o | output | TAP_W | Chosen tap, or 0 on failure |
| width_o | output | TAP_W | Span of the final window |
| fail_o | output | 2 | Result code: 00 ok, 01 no window, 10 window too narrow |

## Verification
The hardest situations to reach from the ports are the window rules that depend on history: a window that closes below the minimum span and is later extended across the failing taps, a window of exactly span 4, and a failure caused only by a missing lock rather than an error. The bench's checker model derives its lock and error flags from per-tap masks, indexed by the tap currently on `dly_val_o` and the lane selected by `lane_q_o`. Each scenario is therefore a choice of masks, and the gaps in those masks are placed to produce each of these histories. A start pulse sent in the middle of one sweep covers the ignored-start rule.

// File: rtl/dly_win_cal_pkg.sv
package dly_win_cal_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_LOAD,
    CS_SETTLE,
    CS_ARM,
    CS_DWELL,
    CS_APPLY,
    CS_DONE
  } cal_state_e;

  localparam logic [1:0] FC_OK     = 2'b00;
  localparam logic [1:0] FC_NONE   = 2'b01;
  localparam logic [1:0] FC_NARROW = 2'b10;

  // window span: distance from first to last passing tap
  function automatic int unsigned win_span(int unsigned first, int unsigned last);
    return last - first;
  endfunction

  // chosen tap: midpoint of the window, rounded down
  function automatic int unsigned win_mid(int unsigned first, int unsigned last);
    return (first + last) / 2;
  endfunction

endpackage

// File: rtl/dwc_timer.sv
module dwc_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] lim_i,
  output logic          last_o
);
  logic [CW-1:0] cnt;

  assign last_o = run_i && (cnt == lim_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run_i || last_o) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dwc_window.sv
module dwc_window #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          upd_i,
  input  logic          pass_i,
  input  logic [TW-1:0] tap_i,
  output logic          open_o,
  output logic [TW-1:0] start_o,
  output logic [TW-1:0] stop_o,
  output logic          nxt_open_o,
  output logic [TW-1:0] nxt_start_o,
  output logic [TW-1:0] nxt_stop_o
);
  always_comb begin
    nxt_open_o  = open_o | pass_i;
    nxt_start_o = open_o ? start_o : tap_i;
    nxt_stop_o  = pass_i ? tap_i : stop_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o  <= 1'b0;
      start_o <= '0;
      stop_o  <= '0;
    end else if (clr_i) begin
      open_o  <= 1'b0;
      start_o <= '0;
      stop_o  <= '0;
    end else if (upd_i) begin
      open_o  <= nxt_open_o;
      start_o <= nxt_start_o;
      stop_o  <= nxt_stop_o;
    end
  end
endmodule

// File: rtl/dly_win_cal.sv
module dly_win_cal
  import dly_win_cal_pkg::*;
#(
  parameter int TAP_W      = 5,
  parameter int DWELL_CYC  = 2**21,
  parameter int SETTLE_CYC = 4,
  parameter int MIN_SPAN   = 4,
  parameter int REST_TAP   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic [TAP_W-1:0] dly_val_o,
  output logic             dly_load_o,
  output logic             chk_en_o,
  output logic             lane_q_o,
  input  logic             ilock_i,
  input  logic             ierr_i,
  input  logic             qlock_i,
  input  logic             qerr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [TAP_W-1:0] tap_o,
  output logic [TAP_W-1:0] width_o,
  output logic [1:0]       fail_o
);
  localparam int               LONGEST = (DWELL_CYC > SETTLE_CYC) ? DWELL_CYC : SETTLE_CYC;
  localparam int               CW      = $clog2(LONGEST) + 1;
  localparam logic [TAP_W-1:0] TAP_TOP = {TAP_W{1'b1}};
  localparam logic [TAP_W-1:0] MIN_W   = TAP_W'(MIN_SPAN);

  cal_state_e       state;
  logic [TAP_W-1:0] cur_tap;
  logic             i_ok;

  // named internal events
  logic             start_acc;
  logic             tmr_run, tmr_last;
  logic [CW-1:0]    tmr_lim;
  logic             meas_end, q_end;
  logic             lane_ok, tap_pass;
  logic             stop_early;
  logic             sweep_end_evt;
  logic             win_ok;
  logic             done_nxt;

  logic             w_open, w_nopen;
  logic [TAP_W-1:0] w_start, w_stop, w_nstart, w_nstop;
  logic [TAP_W-1:0] span_now, span_nxt, mid_nxt;

  assign tmr_run = (state == CS_SETTLE) || (state == CS_DWELL);
  assign tmr_lim = (state == CS_SETTLE) ? CW'(SETTLE_CYC) : CW'(DWELL_CYC);

  dwc_timer #(.CW(CW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .run_i(tmr_run), .lim_i(tmr_lim), .last_o(tmr_last)
  );

  assign start_acc = start_i && ((state == CS_IDLE) || (state == CS_DONE));
  assign meas_end  = tmr_last && (state == CS_DWELL);
  assign q_end     = meas_end && lane_q_o;
  assign lane_ok   = lane_q_o ? (qlock_i && !qerr_i) : (ilock_i && !ierr_i);
  assign tap_pass  = i_ok && lane_ok;

  dwc_window #(.TW(TAP_W)) win_i (
    .clk(clk), .rst_n(rst_n), .clr_i(start_acc), .upd_i(q_end), .pass_i(tap_pass),
    .tap_i(cur_tap), .open_o(w_open), .start_o(w_start), .stop_o(w_stop),
    .nxt_open_o(w_nopen), .nxt_start_o(w_nstart), .nxt_stop_o(w_nstop)
  );

  assign span_now      = TAP_W'(win_span(w_start, w_stop));
  assign span_nxt      = TAP_W'(win_span(w_nstart, w_nstop));
  assign mid_nxt       = TAP_W'(win_mid(w_nstart, w_nstop));
  assign stop_early    = !tap_pass && w_open && (span_now >= MIN_W);
  assign sweep_end_evt = q_end && (stop_early || (cur_tap == TAP_TOP));
  assign win_ok        = w_nopen && (span_nxt >= MIN_W);
  assign done_nxt      = (state == CS_APPLY) || (sweep_end_evt && !win_ok);

  assign dly_load_o = (state == CS_LOAD) || (state == CS_APPLY);
  assign chk_en_o   = (state == CS_DWELL);
  assign busy_o     = (state != CS_IDLE) && (state != CS_DONE);
  assign done_o     = (state == CS_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CS_IDLE;
      cur_tap   <= '0;
      i_ok      <= 1'b0;
      lane_q_o  <= 1'b0;
      dly_val_o <= TAP_W'(REST_TAP);
      tap_o     <= '0;
      width_o   <= '0;
      fail_o    <= FC_OK;
    end else begin
      case (state)
        CS_IDLE, CS_DONE: begin
          if (start_acc) begin
            state     <= CS_LOAD;
            cur_tap   <= '0;
            dly_val_o <= '0;
            lane_q_o  <= 1'b0;
            tap_o     <= '0;
            width_o   <= '0;
            fail_o    <= FC_OK;
          end else begin
            state <= CS_IDLE;
          end
        end
        CS_LOAD:   state <= CS_SETTLE;
        CS_SETTLE: if (tmr_last) state <= CS_ARM;
        CS_ARM:    state <= CS_DWELL;
        CS_DWELL: begin
          if (meas_end) begin
            if (!lane_q_o) begin
              i_ok     <= lane_ok;
              lane_q_o <= 1'b1;
              state    <= CS_ARM;
            end else begin
              lane_q_o <= 1'b0;
              if (!sweep_end_evt) begin
                cur_tap   <= cur_tap + 1'b1;
                dly_val_o <= cur_tap + 1'b1;
                state     <= CS_LOAD;
              end else if (!w_nopen) begin
                fail_o <= FC_NONE;
                state  <= CS_DONE;
              end else if (!win_ok) begin
                fail_o  <= FC_NARROW;
                width_o <= span_nxt;
                state   <= CS_DONE;
              end else begin
                tap_o     <= mid_nxt;
                width_o   <= span_nxt;
                dly_val_o <= mid_nxt;
                state     <= CS_APPLY;
              end
            end
          end
        end
        CS_APPLY: state <= CS_DONE;
        default:  state <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dly_win_cal_chk.sv
module dly_win_cal_chk #(
  parameter int TAP_W    = 5,
  parameter int MIN_SPAN = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [TAP_W-1:0] dly_val_o,
  input logic             dly_load_o,
  input logic             chk_en_o,
  input logic             lane_q_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [TAP_W-1:0] width_o,
  input logic [1:0]       fail_o,
  input logic             done_nxt
);
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dly_load_o |=> !dly_load_o); // R2
  AST_VAL_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_val_o != $past(dly_val_o)) |-> dly_load_o); // R2
  AST_CHK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en_o |-> busy_o); // R3
  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_o && $past(chk_en_o)) |-> $stable(lane_q_o)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    done_nxt |=> done_o); // R9
  AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fail_o != 2'b11)); // R7
  AST_OK_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (fail_o == 2'b00)) |-> (32'(width_o) >= MIN_SPAN)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_nxt) |=> busy_o); // R10
endmodule

bind dly_win_cal dly_win_cal_chk #(.TAP_W(TAP_W), .MIN_SPAN(MIN_SPAN)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .dly_val_o(dly_val_o),
  .dly_load_o(dly_load_o), .chk_en_o(chk_en_o), .lane_q_o(lane_q_o),
  .busy_o(busy_o), .done_o(done_o), .width_o(width_o), .fail_o(fail_o),
  .done_nxt(done_nxt)
);

// File: tb/dly_win_cal_tb_top.sv
module dly_win_cal_tb_top;
  localparam int TW = 5;
  localparam int DW = 6;
  localparam int ST = 3;
  localparam int NT = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] lock_m = '0, pi_m = '0, pq_m = '0;
  logic [TW-1:0] dly_val, tap, width;
  logic dly_load, chk_en, lane_q, busy, done;
  logic [1:0] fail;
  logic lk_i, er_i, lk_q, er_q;

  // checker/ADC model: flags follow the applied tap and the lane under test
  assign lk_i = chk_en && !lane_q && lock_m[dly_val];
  assign er_i = chk_en && !lane_q && !pi_m[dly_val];
  assign lk_q = chk_en && lane_q && lock_m[dly_val];
  assign er_q = chk_en && lane_q && !pq_m[dly_val];

  dly_win_cal #(.TAP_W(TW), .DWELL_CYC(DW), .SETTLE_CYC(ST), .MIN_SPAN(4), .REST_TAP(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dly_val_o(dly_val), .dly_load_o(dly_load),
    .chk_en_o(chk_en), .lane_q_o(lane_q), .ilock_i(lk_i), .ierr_i(er_i), .qlock_i(lk_q),
    .qerr_i(er_q), .busy_o(busy), .done_o(done), .tap_o(tap), .width_o(width), .fail_o(fail)
  );

  int n_cmp = 0, n_bad = 0;
  int e_val = 16, e_load = 0, e_chk = 0, e_lane = 0, e_busy = 0, e_done = 0;
  int e_tap = 0, e_width = 0, e_fail = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rng(int lo, int hi);
    logic [31:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  // reference model: one expectation set per clock
  task automatic run_cal();
    int ws = -1, we = -1;
    bit ok_i = 0, ok_q = 0, pass, fin;
    e_tap = 0; e_width = 0; e_fail = 0; e_done = 0; e_busy = 1;
    for (int t = 0; t < NT; t++) begin
      e_val = t; e_load = 1; e_chk = 0; e_lane = 0;
      @(posedge clk);
      e_load = 0;
      repeat (ST) @(posedge clk);
      for (int ln = 0; ln < 2; ln++) begin
        e_lane = ln; e_chk = 0;
        @(posedge clk);
        e_chk = 1;
        repeat (DW - 1) @(posedge clk);
        @(negedge clk);
        if (ln == 0) ok_i = lk_i && !er_i;
        else         ok_q = lk_q && !er_q;
        @(posedge clk);
      end
      e_chk = 0; e_lane = 0;
      pass = ok_i && ok_q;
      fin = 0;
      if (pass) begin
        if (ws < 0) ws = t;
        we = t;
      end else if (ws >= 0 && we - ws >= 4) fin = 1;
      if (t == NT - 1) fin = 1;
      if (fin) begin
        if (ws < 0) e_fail = 1;
        else if (we - ws < 4) begin e_fail = 2; e_width = we - ws; end
        else begin
          e_tap = (ws + we) / 2; e_width = we - ws; e_val = e_tap; e_load = 1;
          @(posedge clk);
          e_load = 0;
        end
        e_busy = 0; e_done = 1;
        return;
      end
    end
  endtask

  initial begin
    wait (rst_n);
    forever begin
      @(posedge clk);
      if (start) run_cal();
      else e_done = 0;
    end
  end

  // compare every clock
  always @(negedge clk) begin
    chk("R2 dly_val", int'(dly_val), e_val);
    chk("R2 dly_load", int'(dly_load), e_load);
    chk("R3 R11 chk_en", int'(chk_en), e_chk);
    chk("R4 lane_q", int'(lane_q), e_lane);
    chk("R10 busy", int'(busy), e_busy);
    chk("R9 done", int'(done), e_done);
    chk("R8 tap", int'(tap), e_tap);
    chk("R6 width", int'(width), e_width);
    chk("R7 fail", int'(fail), e_fail);
  end

  task automatic scen(string nm, logic [31:0] lk, logic [31:0] pi, logic [31:0] pq,
                      int xf, int xt, int xw, int xv, bit poke);
    lock_m = lk; pi_m = pi; pq_m = pq;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1;            // R10: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    $display("scenario %s finished", nm);
    chk("R7 final code", int'(fail), xf);
    chk("R8 final tap", int'(tap), xt);
    chk("R6 final width", int'(width), xw);
    chk("R5 R8 final delay value", int'(dly_val), xv);
    repeat (4) @(negedge clk);
    chk("R9 tap held", int'(tap), xt);
    chk("R9 code held", int'(fail), xf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset dly_val", int'(dly_val), 16);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 early stop after window 10..20
    scen("S1", rng(10,20), rng(10,20), rng(10,20), 0, 15, 10, 15, 1'b1);
    // R7 no lock anywhere
    scen("S2", 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 31, 1'b0);
    // R7 narrow window 5..7
    scen("S3", rng(5,7), rng(5,7), rng(5,7), 2, 0, 2, 31, 1'b0);
    // R6 window extended across a gap: 3..9
    scen("S4", rng(3,4) | rng(6,9), rng(3,4) | rng(6,9), rng(3,4) | rng(6,9), 0, 6, 6, 6, 1'b0);
    // R6 window open at the last tap: 26..31
    scen("S5", rng(26,31), rng(26,31), rng(26,31), 0, 28, 5, 28, 1'b0);
    // R5 Q-lane error at 15 closes a span-4 window
    scen("S6", 32'hFFFF_FFFF, rng(10,20), rng(10,20) & ~(32'h1 << 15), 0, 12, 4, 12, 1'b0);
    // R5 missing lock at 5 fails that tap
    scen("S7", 32'hFFFF_FFFF & ~(32'h1 << 5), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2, 4, 2, 1'b0);
    // R7 span 3 never reaches the minimum
    scen("S8", rng(0,3), rng(0,3), rng(0,3), 2, 0, 3, 31, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule